// File: doc/BRIEF.md
# Serial GPIO Shift Engine

This block carries up to 80 general-purpose pin values over a four-wire serial link to and from an external shift-register chain. While enabled, it runs frames back to back. Each frame opens with a strobe that tells the remote chain to latch its parallel inputs and to update its outputs. The engine then clocks out one output bit per pin and clocks in one input bit per pin, lowest pin index first. The serial clock is derived from the bus clock by a programmable divider. The frame length is set by a pin-count field given in units of eight pins.

Software sees one control word, one value word per bank of 32 pins and one read-back word per bank. Pin `p` lives in bank `p >> 5` at bit `p & 31`. A write to a value word sets the levels that will be shifted out. A read of a value word returns the input levels taken in by the last complete frame. A read-back word returns the output levels that the running frame is actually shifting. Input words change only at the end of a complete frame, and output and configuration changes are taken only at a frame start, so software never sees a half-updated word.

Top module: `sgx_engine`

## Requirements
- R1: After reset every readable word returns zero and `ser_clk`, `ser_load` and `ser_dout` are low.
- R2: The control word (address 0) holds enable in bit 0, the pin-count field in bits 9:6 and the divider in bits 31:16. A read returns exactly those fields, and all other bits read zero.
- R3: One serial clock period is 2 × (divider + 1) bus cycles, low half first. `ser_load` is high for exactly one serial period at the start of every frame.
- R4: After the strobe, a frame shifts 8 × units bits, where units is the pin-count field clamped to 10. A pin-count of zero keeps the engine idle with `ser_load` and `ser_clk` low. Frame length is therefore (bits + 1) serial periods.
- R5: In bit slot k after the strobe, `ser_dout` carries the output level of pin k. `ser_dout` changes only together with a falling `ser_clk`.
- R6: `ser_din` is sampled when `ser_clk` rises in slot k and becomes pin k's input. Reading value word 1+b returns pins 32b..32b+31 of the last complete frame. Pins at or above the frame's bit count read zero.
- R7: Input words are updated only at the end of a complete frame. A read in the middle of a frame returns the previous frame's values, and a frame cut short by clearing enable commits nothing.
- R8: Read-back word 5+b returns the output levels latched at the start of the running frame. A value-word write that lands on the same bus edge as a frame start, or later, appears only in the following frame.
- R9: A divider or pin-count change written while enabled takes effect at the next frame start. The running frame keeps its old timing and length.
- R10: After enable is cleared, `ser_clk` and `ser_load` are low from the second bus edge after the write onward.
- R11: Address 4 reads zero. Bank 2 holds pins 64..79 in bits 15:0, and its bits 31:16 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| ser_clk | output | 1 | Serial shift clock |
| ser_load | output | 1 | Frame latch strobe |
| ser_dout | output | 1 | Serial output data |
| ser_din | input | 1 | Serial input data |

## Verification
A bus write to an output value word and the frame-start snapshot of those words can fall on the same bus edge, and the design gives the snapshot the old contents. The bench measures the frame length at run time and then times a write to land on exactly the edge where the next frame's strobe rises. It then judges the case three ways: the serial bits captured in that frame, the read-back word during that frame, and the bits captured in the frame after it, which must carry the new value.

// File: rtl/sgx_pkg.sv
package sgx_pkg;
   localparam int REG_W         = 32;
   localparam int EN_BIT        = 0;
   localparam int PCNT_LSB      = 6;
   localparam int PCNT_W        = 4;
   localparam int DIV_LSB       = 16;
   localparam int DIV_W         = 16;
   localparam int PINS_PER_UNIT = 8;

   typedef struct packed {
      logic [DIV_W-1:0]  div;
      logic [PCNT_W-1:0] pcnt;
      logic              en;
   } sgx_cfg_t;

   function automatic logic [REG_W-1:0] cfg_to_word(input sgx_cfg_t c);
      logic [REG_W-1:0] w;
      w                       = '0;
      w[EN_BIT]               = c.en;
      w[PCNT_LSB +: PCNT_W]   = c.pcnt;
      w[DIV_LSB +: DIV_W]     = c.div;
      return w;
   endfunction

   function automatic sgx_cfg_t word_to_cfg(input logic [REG_W-1:0] w);
      sgx_cfg_t c;
      c.en   = w[EN_BIT];
      c.pcnt = w[PCNT_LSB +: PCNT_W];
      c.div  = w[DIV_LSB +: DIV_W];
      return c;
   endfunction
endpackage

// File: rtl/sgx_regs.sv
module sgx_regs
   import sgx_pkg::*;
#(
   parameter int MAX_PINS = 80,
   parameter int BANK_W   = 32,
   parameter int ADDR_W   = 3,
   parameter int VAL_BASE = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [REG_W-1:0]    wr_data,
   output sgx_cfg_t            cfg,
   output logic [MAX_PINS-1:0] out_vec
);
   localparam int NUM_BANKS = (MAX_PINS + BANK_W - 1) / BANK_W;

   // R2: control fields captured from their fixed bit positions
   always_ff @(posedge clk) begin
      if (!rst_n)
         cfg <= '0;
      else if (wr_en && wr_addr == '0)
         cfg <= word_to_cfg(wr_data);
   end

   // R11: the last bank keeps only as many bits as it has pins
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_out_bank
      localparam int LO = b * BANK_W;
      localparam int BW = (MAX_PINS - LO < BANK_W) ? (MAX_PINS - LO) : BANK_W;
      logic [BW-1:0] bank_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            bank_q <= '0;
         else if (wr_en && wr_addr == ADDR_W'(VAL_BASE + b))
            bank_q <= wr_data[BW-1:0];
      end
      assign out_vec[LO +: BW] = bank_q;
   end
endmodule

// File: rtl/sgx_half_tick.sv
module sgx_half_tick #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == div);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   // R3
   half_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> cnt <= div);
endmodule

// File: rtl/sgx_frame_seq.sv
module sgx_frame_seq
   import sgx_pkg::*;
#(
   parameter int MAX_PINS = 80,
   parameter int IDX_W    = $clog2(MAX_PINS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  sgx_cfg_t            cfg,
   input  logic [MAX_PINS-1:0] out_vec,
   input  logic                half_tick,
   input  logic                ser_din,
   output logic                run,
   output logic [DIV_W-1:0]    div_lat,
   output logic                ser_clk,
   output logic                ser_load,
   output logic                ser_dout,
   output logic [MAX_PINS-1:0] in_vec,
   output logic [MAX_PINS-1:0] snap
);
   localparam int MAX_UNITS = MAX_PINS / PINS_PER_UNIT;

   logic                phase;
   logic [IDX_W-1:0]    pidx, n_lat, n_req, slot;
   logic [PCNT_W-1:0]   units;
   logic [MAX_PINS-1:0] shift_q;
   logic                cfg_ok, last_half, frame_done, begin_fr;

   // R4: pin-count clamped to the supported maximum
   assign units      = (cfg.pcnt > PCNT_W'(MAX_UNITS)) ? PCNT_W'(MAX_UNITS) : cfg.pcnt;
   assign n_req      = IDX_W'(units) * IDX_W'(PINS_PER_UNIT);
   assign cfg_ok     = cfg.en && (cfg.pcnt != '0);
   assign last_half  = run && half_tick && phase;
   assign frame_done = cfg.en && last_half && (pidx == n_lat);
   assign begin_fr   = cfg_ok && (!run || frame_done);
   assign slot       = pidx - IDX_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run     <= 1'b0;
         phase   <= 1'b0;
         pidx    <= '0;
         n_lat   <= '0;
         div_lat <= '0;
         snap    <= '0;
         shift_q <= '0;
         in_vec  <= '0;
      end else if (!cfg.en) begin
         // R10 / R7: abort without commit
         run   <= 1'b0;
         phase <= 1'b0;
         pidx  <= '0;
      end else if (begin_fr) begin
         // R8 / R9: snapshot and configuration taken at frame start
         run     <= 1'b1;
         phase   <= 1'b0;
         pidx    <= '0;
         n_lat   <= n_req;
         div_lat <= cfg.div;
         snap    <= out_vec;
         shift_q <= '0;
         if (frame_done)
            in_vec <= shift_q;
      end else if (frame_done) begin
         run    <= 1'b0;
         phase  <= 1'b0;
         pidx   <= '0;
         in_vec <= shift_q;
      end else if (run && half_tick) begin
         if (!phase) begin
            // R6: rising serial edge samples the input
            phase <= 1'b1;
            if (pidx != '0)
               shift_q[slot] <= ser_din;
         end else begin
            phase <= 1'b0;
            pidx  <= pidx + 1'b1;
         end
      end
   end

   assign ser_clk  = run && phase;
   assign ser_load = run && (pidx == '0);
   assign ser_dout = run && (pidx != '0) && snap[slot];

   // R3
   load_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_load) && run |-> $fell(ser_clk));
   // R5
   dout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && $past(run) && !$stable(ser_dout) |-> $fell(ser_clk));
   // R7
   commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(in_vec) |-> $rose(ser_load) || $fell(run));
   // R8
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(snap) |-> $rose(ser_load));
   // R10
   idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.en |=> !ser_clk && !ser_load);
   // R4
   zero_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run && cfg.pcnt == '0 |=> !run);
endmodule

// File: rtl/sgx_engine.sv
module sgx_engine
   import sgx_pkg::*;
#(
   parameter int MAX_PINS = 80,
   parameter int BANK_W   = 32,
   parameter int ADDR_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output logic              ser_clk,
   output logic              ser_load,
   output logic              ser_dout,
   input  logic              ser_din
);
   localparam int NUM_BANKS = (MAX_PINS + BANK_W - 1) / BANK_W;
   localparam int IDX_W     = $clog2(MAX_PINS + 1);
   localparam int VAL_BASE  = 1;
   localparam int RB_BASE   = VAL_BASE + NUM_BANKS + 1;

   if (MAX_PINS % PINS_PER_UNIT != 0) begin : g_bad_pins
      $error("MAX_PINS must be a multiple of the pin unit");
   end
   if (MAX_PINS > PINS_PER_UNIT * ((1 << PCNT_W) - 1)) begin : g_bad_range
      $error("MAX_PINS exceeds the pin-count field range");
   end
   if (BANK_W > REG_W) begin : g_bad_bank
      $error("BANK_W wider than the register word");
   end
   if (RB_BASE + NUM_BANKS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   sgx_cfg_t            cfg;
   logic [MAX_PINS-1:0] out_vec, in_vec, snap;
   logic                run, half_tick;
   logic [DIV_W-1:0]    div_lat;

   sgx_regs #(
      .MAX_PINS (MAX_PINS),
      .BANK_W   (BANK_W),
      .ADDR_W   (ADDR_W),
      .VAL_BASE (VAL_BASE)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .cfg     (cfg),
      .out_vec (out_vec)
   );

   sgx_half_tick #(
      .DIV_W (DIV_W)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .div   (div_lat),
      .tick  (half_tick)
   );

   sgx_frame_seq #(
      .MAX_PINS (MAX_PINS),
      .IDX_W    (IDX_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (cfg),
      .out_vec   (out_vec),
      .half_tick (half_tick),
      .ser_din   (ser_din),
      .run       (run),
      .div_lat   (div_lat),
      .ser_clk   (ser_clk),
      .ser_load  (ser_load),
      .ser_dout  (ser_dout),
      .in_vec    (in_vec),
      .snap      (snap)
   );

   logic [REG_W-1:0] in_w [NUM_BANKS];
   logic [REG_W-1:0] rb_w [NUM_BANKS];

   // R11: partial last bank zero-extended
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_rd_bank
      localparam int LO = b * BANK_W;
      localparam int BW = (MAX_PINS - LO < BANK_W) ? (MAX_PINS - LO) : BANK_W;
      assign in_w[b] = REG_W'(in_vec[LO +: BW]);
      assign rb_w[b] = REG_W'(snap[LO +: BW]);
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == '0)
         rd_data = cfg_to_word(cfg);
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (rd_addr == ADDR_W'(VAL_BASE + b))
            rd_data = in_w[b];
         if (rd_addr == ADDR_W'(RB_BASE + b))
            rd_data = rb_w[b];
      end
   end
endmodule

// File: tb/test_sgx_engine.sv
`timescale 1ns/1ps
module test_sgx_engine;
   localparam int MAXP = 80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] wr_data = '0;
   wire  [31:0] rd_data;
   wire         ser_clk, ser_load, ser_dout, ser_din;

   always #5 clk = ~clk;

   sgx_engine i_sgx_engine (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
      .ser_clk (ser_clk), .ser_load (ser_load), .ser_dout (ser_dout),
      .ser_din (ser_din)
   );

   int nerr = 0, nchk = 0, cyc = 0;
   bit done = 1'b0;

   // remote shift chain model
   logic [MAXP-1:0] remote = '0, cap = '0;
   int bitcnt = 0, last_bits = 0;
   always @(posedge ser_clk) begin
      if (ser_load) bitcnt = 0;
      else begin
         if (bitcnt < MAXP) cap[bitcnt] = ser_dout;
         bitcnt++;
      end
   end
   always @(posedge ser_load) last_bits = bitcnt;
   assign ser_din = (bitcnt < MAXP) ? remote[bitcnt] : 1'b0;

   // div, pin-count field, output pattern, remote input pattern
   localparam logic [179:0] VEC [4] = '{
      {16'd0, 4'd10, 80'hF0E1_D2C3_B4A5_9687_7869, 80'h1357_9BDF_2468_ACE0_5A5A},
      {16'd1, 4'd3,  80'hAAAA_5555_CCCC_3333_0F0F, 80'h0123_4567_89AB_CDEF_FEDC},
      {16'd3, 4'd15, 80'h8000_0000_0000_0000_0001, 80'h7FFF_0000_FFFF_0001_8000},
      {16'd2, 4'd1,  80'h0000_1111_2222_3333_44A5, 80'hFFFF_FFFF_FFFF_FFFF_FF3C}
   };

   task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   function automatic logic [31:0] ctrl_word(input logic [15:0] dv, input logic [3:0] pf, input logic en);
      return {dv, 6'b0, pf, 5'b0, en};
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         nerr++; nchk++;
         $display("FAIL watchdog (all) act=%0d cycles exp=finished", cyc);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      realtime t0, t1, t2, t3;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         check("R1 reset word", d, 0);
      end
      check("R1 serial idle", {ser_clk, ser_load, ser_dout}, 0);

      // R2 control fields
      wr(0, 32'hABCD_03C0); rd(0, d);
      check("R2 ctrl fields", d, 32'hABCD_03C0);
      wr(0, 32'h0000_0C3E); rd(0, d);
      check("R2 unused bits", d, 0);
      // R11 hole in the map
      rd(4, d);
      check("R11 addr4", d, 0);

      // table-driven frames
      for (int v = 0; v < 4; v++) begin
         logic [15:0] dv; logic [3:0] pf; logic [79:0] op, ip, mask;
         int n, per;
         {dv, pf, op, ip} = VEC[v];
         n    = ((pf > 10) ? 10 : int'(pf)) * 8;
         mask = (n == 80) ? {80{1'b1}} : ((80'd1 << n) - 80'd1);
         per  = 2 * (int'(dv) + 1);
         wr(0, 0);
         repeat (3) @(negedge clk);
         wr(1, op[31:0]); wr(2, op[63:32]); wr(3, {16'hFFFF, op[79:64]});
         remote = ip; cap = '0;
         wr(0, ctrl_word(dv, pf, 1'b1));
         @(posedge ser_load); t0 = $realtime;
         @(negedge ser_load); t1 = $realtime;
         @(posedge ser_load); t2 = $realtime;
         @(negedge clk);
         check("R3 load width", int'((t1 - t0) / 10.0), per);
         check("R4 frame length", int'((t2 - t0) / 10.0), (n + 1) * per);
         check("R4 bit count", last_bits, n);
         check("R5 dout order", cap & mask, op & mask);
         for (int b = 0; b < 3; b++) begin
            logic [79:0] ie;
            ie = (ip & mask) >> (32 * b);
            rd(3'(1 + b), d);
            check("R6 input word", d, ie[31:0]);
            ie = op >> (32 * b);
            rd(3'(5 + b), d);
            check("R8 R11 readback", d, ie[31:0]);
         end
      end

      // R8 write on the frame-start edge
      wr(0, 0);
      wr(1, 32'h5A); remote = '0; cap = '0;
      wr(0, ctrl_word(0, 1, 1'b1));
      @(posedge ser_load);
      repeat (17) @(posedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 1; wr_data = 32'hC3;
      @(negedge clk);
      wr_en = 1'b0;
      rd(5, d);
      check("R8 readback same-edge", d, 32'h5A);
      @(posedge ser_load); @(negedge clk);
      check("R8 frame old value", cap[7:0], 8'h5A);
      @(posedge ser_load); @(negedge clk);
      check("R8 frame new value", cap[7:0], 8'hC3);
      rd(5, d);
      check("R8 readback new", d, 32'hC3);

      // R9 divider and pin-count change mid-frame
      wr(0, 0);
      wr(0, ctrl_word(1, 1, 1'b1));
      @(posedge ser_load); t0 = $realtime;
      repeat (5) @(negedge clk);
      wr(0, ctrl_word(3, 2, 1'b1));
      @(posedge ser_load); t1 = $realtime;
      @(negedge ser_load); t2 = $realtime;
      @(posedge ser_load); t3 = $realtime;
      check("R9 old frame kept", int'((t1 - t0) / 10.0), 36);
      check("R9 new load width", int'((t2 - t1) / 10.0), 8);
      check("R9 new frame length", int'((t3 - t1) / 10.0), 136);

      // R4 zero pin count stays idle
      wr(0, 0);
      wr(0, ctrl_word(2, 0, 1'b1));
      begin
         int hi;
         hi = 0;
         repeat (100) begin
            @(negedge clk);
            if (ser_load || ser_clk) hi++;
         end
         check("R4 zero pins idle", hi, 0);
      end

      // R7 atomic commit and abort, R10 disable
      wr(0, 0);
      remote = {48'h0, 32'hDEAD_BEEF};
      wr(0, ctrl_word(0, 10, 1'b1));
      @(posedge ser_load); @(posedge ser_load);
      @(negedge clk);
      rd(1, d);
      check("R6 committed word", d, 32'hDEAD_BEEF);
      remote = {48'h0, 32'h0BAD_F00D};
      repeat (40) @(negedge clk);
      rd(1, d);
      check("R7 mid-frame read", d, 32'hDEAD_BEEF);
      wr(0, 0);
      @(negedge clk);
      check("R10 serial low", {ser_clk, ser_load}, 0);
      repeat (300) @(negedge clk);
      rd(1, d);
      check("R7 aborted frame", d, 32'hDEAD_BEEF);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule